// File: doc/BRIEF.md
# Bus configuration register controller

This block holds the bus set-up state of a small 8-bit microcontroller in three byte-wide registers that software writes and reads back. The first selects the bus mode and turns the three chip-enable pins on or off, the second holds the page of the stack area, and the third holds a wait-state code and the enable for the bus-request/acknowledge pin pair. A strap pin tells the block whether the part boots from internal ROM or from external ROM, and the reset values of the first register follow it.

From these registers the block derives the effective bus mode and the pin multiplexing. Each chip-enable pin and the acknowledge pin either carry their bus function or fall back to a general output port value. The request pin either feeds the core or serves as a general input bit. The block also keeps every interrupt line and NMI masked until software has written both the mode and the stack-page registers. After each stack-page write it adds one more instruction of masking. For every external access it pulls a ready line low for as many clocks as the wait code asks.

The register port, strap, strobes and pin lines are plain control signals with no handshake. The only flow control is the wait stall. While `ext_ready` is low the core must hold its external access. A new `ext_start` pulse is taken only when `ext_ready` is high, and a pulse that arrives during a stall is dropped.

Top module: `busconf_ctrl`

## Requirements
- R1: After reset, register 0 reads 81h when `strap_ext_rom` is 1 and 00h when it is 0. Registers 1 and 2 read 00h.
- R2: With `strap_ext_rom` = 0, `bus_mode` equals register 0 bits 7:6, using the encoding 3 = expansion maximum, 2 = expansion minimum, 1 = single-chip maximum and 0 = single-chip minimum.
- R3: With `strap_ext_rom` = 1, `bus_mode` bit 1 is always 1 and `bus_mode` bit 0 equals register 0 bit 6, so single-chip mode is never reported.
- R4: For each i in 0..2, `ce_pin[i]` is `ce_raw[i]` when register 0 bit i is 1 and `port_ce[i]` when it is 0.
- R5: A write to register 1 is stored if the data is 00h, or if `bus_mode` bit 1 is 1 and the data is at most 27h. Any other write leaves the register unchanged. `stack_page` always equals register 1.
- R6: Reads through `reg_sel`/`rd_data` return the stored bits: register 0 bits 7, 6 and 2:0, register 2 bits 7:4, and 0 in every other bit. `reg_sel` = 3 reads 00h.
- R7: `irq_out` and `nmi_out` are held at 0 until register 0 and register 1 have each been written at least once since reset. After that they follow `irq_in` and `nmi_in`.
- R8: After any write to register 1, whether it is stored or not, the interrupt outputs stay 0 until the second `insn_done` pulse after the write.
- R9: Register 2 bits 6:4 hold a code n. An `ext_start` pulse accepted while `ext_ready` is high drives `ext_ready` low for exactly n clock cycles, starting on the next cycle. n = 0 gives no stall, and pulses that arrive during a stall are ignored.
- R10: With register 2 bit 7 set to 1, `breq_core` = `breq_pin`, `back_pin` = `back_core` and `breq_gpi` = 0. With it cleared, `breq_core` = 0, `breq_gpi` = `breq_pin` and `back_pin` = `port_back`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_ext_rom | input | 1 | 1 = boot from external ROM, 0 = internal ROM |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register index 0..2 |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| bus_mode | output | 2 | Effective bus mode |
| stack_page | output | 8 | Stack page |
| ce_raw | input | 3 | Chip-enable signals from the address decoder |
| port_ce | input | 3 | General output port values for the chip-enable pins |
| ce_pin | output | 3 | Chip-enable pin drive |
| breq_pin | input | 1 | Bus request pin |
| breq_core | output | 1 | Bus request to the core |
| breq_gpi | output | 1 | Request pin as a general input bit |
| back_core | input | 1 | Bus acknowledge from the core |
| port_back | input | 1 | General output port value for the acknowledge pin |
| back_pin | output | 1 | Bus acknowledge pin drive |
| insn_done | input | 1 | Instruction boundary strobe |
| irq_in | input | NUM_IRQ | Maskable interrupt requests |
| nmi_in | input | 1 | Non-maskable interrupt request |
| irq_out | output | NUM_IRQ | Gated interrupt requests |
| nmi_out | output | 1 | Gated NMI |
| ext_start | input | 1 | Start of an external access |
| ext_ready | output | 1 | Low while the access is stalled |

## Verification
The assertions check on every cycle that:
- external-ROM strapping never reports single-chip mode;
- the stack page never exceeds its limit;
- a stack-page write closes the interrupt gate on the following cycle;
- an accepted access with a non-zero wait code stalls at once, while a zero code never stalls.

The exact stall length for each wait code, the drop of a start pulse that arrives during a stall, and the strap-dependent reset values can only be shown by the bench's scenarios. The same holds for the pin multiplexing across all input patterns, the accept/discard decision over all 256 stack-page values in both modes, and the gate opening only on the second instruction boundary.

// File: rtl/busconf_pkg.sv
package busconf_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE_MIN = 2'b00,
    MODE_SINGLE_MAX = 2'b01,
    MODE_EXP_MIN    = 2'b10,
    MODE_EXP_MAX    = 2'b11
  } bus_mode_e;

  localparam int unsigned CE_N   = 3;
  localparam int unsigned WAIT_W = 3;
  localparam logic [1:0] SEL_MODE  = 2'd0;
  localparam logic [1:0] SEL_STACK = 2'd1;
  localparam logic [1:0] SEL_WAIT  = 2'd2;
endpackage

// File: rtl/busconf_regs.sv
module busconf_regs
  import busconf_pkg::*;
#(
  parameter logic [7:0] PAGE_MAX = 8'h27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_ext_rom,
  input  logic              wr_en,
  input  logic [1:0]        reg_sel,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output bus_mode_e         mode,
  output logic [CE_N-1:0]   ce_en,
  output logic [7:0]        stack_page,
  output logic [WAIT_W-1:0] wait_code,
  output logic              breq_en
);
  logic busmod_q, cpumod_q;
  logic page_ok;

  assign page_ok = (wr_data == 8'h00) || (mode[1] && (wr_data <= PAGE_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busmod_q   <= strap_ext_rom;
      cpumod_q   <= 1'b0;
      ce_en      <= {{(CE_N-1){1'b0}}, strap_ext_rom};
      stack_page <= 8'h00;
      wait_code  <= '0;
      breq_en    <= 1'b0;
    end else if (wr_en) begin
      case (reg_sel)
        SEL_MODE: begin
          busmod_q <= wr_data[7];
          cpumod_q <= wr_data[6];
          ce_en    <= wr_data[CE_N-1:0];
        end
        SEL_STACK: if (page_ok) stack_page <= wr_data;
        SEL_WAIT: begin
          breq_en   <= wr_data[7];
          wait_code <= wr_data[4 +: WAIT_W];
        end
        default: ;
      endcase
    end
  end

  // External-ROM strapping forces the expansion side
  assign mode = bus_mode_e'({busmod_q | strap_ext_rom, cpumod_q});

  always_comb begin
    rd_data = 8'h00;
    case (reg_sel)
      SEL_MODE:  rd_data = {busmod_q, cpumod_q, {(8-2-CE_N){1'b0}}, ce_en};
      SEL_STACK: rd_data = stack_page;
      SEL_WAIT:  rd_data = {breq_en, wait_code, 4'h0};
      default:   rd_data = 8'h00;
    endcase
  end

  p_ext_rom_expansion_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strap_ext_rom |-> mode[1]);

  p_page_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stack_page <= PAGE_MAX);
endmodule

// File: rtl/busconf_irq_gate.sv
module busconf_irq_gate #(
  parameter int unsigned NUM_IRQ    = 8,
  parameter int unsigned HOLD_INSNS = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_wr,
  input  logic               page_wr,
  input  logic               insn_done,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               nmi_in,
  output logic [NUM_IRQ-1:0] irq_out,
  output logic               nmi_out
);
  localparam int unsigned HOLD_LOAD = HOLD_INSNS + 1;
  localparam int unsigned HW = $clog2(HOLD_LOAD + 1);

  logic seen_mode_q, seen_page_q, open;
  logic [HW-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_mode_q <= 1'b0;
      seen_page_q <= 1'b0;
      hold_q      <= '0;
    end else begin
      if (mode_wr) seen_mode_q <= 1'b1;
      if (page_wr) begin
        seen_page_q <= 1'b1;
        hold_q      <= HW'(HOLD_LOAD);
      end else if (insn_done && hold_q != '0) begin
        hold_q <= hold_q - 1'b1;
      end
    end
  end

  assign open    = seen_mode_q && seen_page_q && (hold_q == '0);
  assign irq_out = irq_in & {NUM_IRQ{open}};
  assign nmi_out = nmi_in & open;

  p_page_write_masks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    page_wr |=> (!nmi_out && irq_out == '0));
endmodule

// File: rtl/busconf_wait.sv
module busconf_wait
  import busconf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WAIT_W-1:0] wait_code,
  input  logic              ext_start,
  output logic              ext_ready
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (cnt_q != '0)             cnt_q <= cnt_q - 1'b1;
    else if (ext_start)               cnt_q <= wait_code;
  end

  assign ext_ready = (cnt_q == '0);

  p_stall_begins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_start && ext_ready && wait_code != '0) |=> !ext_ready);

  p_zero_code_no_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_ready && wait_code == '0) |=> ext_ready);
endmodule

// File: rtl/busconf_ctrl.sv
module busconf_ctrl
  import busconf_pkg::*;
#(
  parameter int unsigned NUM_IRQ    = 8,
  parameter int unsigned HOLD_INSNS = 1,
  parameter logic [7:0]  PAGE_MAX   = 8'h27
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strap_ext_rom,
  input  logic               wr_en,
  input  logic [1:0]         reg_sel,
  input  logic [7:0]         wr_data,
  output logic [7:0]         rd_data,
  output logic [1:0]         bus_mode,
  output logic [7:0]         stack_page,
  input  logic [2:0]         ce_raw,
  input  logic [2:0]         port_ce,
  output logic [2:0]         ce_pin,
  input  logic               breq_pin,
  output logic               breq_core,
  output logic               breq_gpi,
  input  logic               back_core,
  input  logic               port_back,
  output logic               back_pin,
  input  logic               insn_done,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               nmi_in,
  output logic [NUM_IRQ-1:0] irq_out,
  output logic               nmi_out,
  input  logic               ext_start,
  output logic               ext_ready
);
  bus_mode_e         mode;
  logic [CE_N-1:0]   ce_en;
  logic [WAIT_W-1:0] wait_code;
  logic              breq_en;

  busconf_regs #(.PAGE_MAX(PAGE_MAX)) regs_i (
    .clk(clk), .rst_n(rst_n), .strap_ext_rom(strap_ext_rom),
    .wr_en(wr_en), .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data),
    .mode(mode), .ce_en(ce_en), .stack_page(stack_page),
    .wait_code(wait_code), .breq_en(breq_en)
  );

  busconf_irq_gate #(.NUM_IRQ(NUM_IRQ), .HOLD_INSNS(HOLD_INSNS)) gate_i (
    .clk(clk), .rst_n(rst_n),
    .mode_wr(wr_en && reg_sel == SEL_MODE),
    .page_wr(wr_en && reg_sel == SEL_STACK),
    .insn_done(insn_done), .irq_in(irq_in), .nmi_in(nmi_in),
    .irq_out(irq_out), .nmi_out(nmi_out)
  );

  busconf_wait wait_i (
    .clk(clk), .rst_n(rst_n), .wait_code(wait_code),
    .ext_start(ext_start), .ext_ready(ext_ready)
  );

  assign bus_mode = mode;

  for (genvar i = 0; i < CE_N; i++) begin : g_ce_mux
    assign ce_pin[i] = ce_en[i] ? ce_raw[i] : port_ce[i];
  end

  assign breq_core = breq_en & breq_pin;
  assign breq_gpi  = ~breq_en & breq_pin;
  assign back_pin  = breq_en ? back_core : port_back;
endmodule

// File: tb/busconf_ctrl_tb_top.sv
module busconf_ctrl_tb_top;
  localparam int NI = 8;

  logic clk = 1'b0, rst_n = 1'b0, strap = 1'b0;
  logic wr_en = 1'b0, insn_done = 1'b0, nmi_in = 1'b0, ext_start = 1'b0;
  logic breq_pin = 1'b0, back_core = 1'b0, port_back = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [2:0] ce_raw = 3'b0, port_ce = 3'b0;
  logic [NI-1:0] irq_in = '0;
  logic [7:0] rd_data, stack_page;
  logic [1:0] bus_mode;
  logic [2:0] ce_pin;
  logic breq_core, breq_gpi, back_pin, nmi_out, ext_ready;
  logic [NI-1:0] irq_out;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  busconf_ctrl #(.NUM_IRQ(NI)) dut_i (
    .clk(clk), .rst_n(rst_n), .strap_ext_rom(strap), .wr_en(wr_en),
    .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data),
    .bus_mode(bus_mode), .stack_page(stack_page), .ce_raw(ce_raw),
    .port_ce(port_ce), .ce_pin(ce_pin), .breq_pin(breq_pin),
    .breq_core(breq_core), .breq_gpi(breq_gpi), .back_core(back_core),
    .port_back(port_back), .back_pin(back_pin), .insn_done(insn_done),
    .irq_in(irq_in), .nmi_in(nmi_in), .irq_out(irq_out), .nmi_out(nmi_out),
    .ext_start(ext_start), .ext_ready(ext_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    strap = s; rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    reg_sel = sel; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [7:0] rd(input logic [1:0] sel);
    reg_sel = sel;
    return 8'h00;
  endfunction

  task automatic rdchk(input string req, input logic [1:0] sel, input logic [7:0] exp);
    reg_sel = sel;
    #1;
    chk(req, {24'h0, rd_data}, {24'h0, exp});
  endtask

  task automatic pulse_insn();
    insn_done = 1'b1;
    @(negedge clk);
    insn_done = 1'b0;
  endtask

  task automatic gate_chk(input string req, input logic open);
    #1;
    chk(req, {23'h0, nmi_out, irq_out}, open ? {23'h0, 1'b1, {NI{1'b1}}} : 32'h0);
  endtask

  task automatic stall_len(input int second_at, output int n);
    int k = 0;
    ext_start = 1'b1;
    @(negedge clk);
    ext_start = 1'b0;
    for (int c = 0; c < 20; c++) begin
      if (c == second_at) ext_start = 1'b1;
      if (ext_ready == 1'b0) k++;
      @(negedge clk);
      ext_start = 1'b0;
    end
    n = k;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] model;
    logic acc;

    // R1 reset values, external ROM strap
    do_reset(1'b1);
    rdchk("R1 reg0 ext", 2'd0, 8'h81);
    rdchk("R1 reg1 ext", 2'd1, 8'h00);
    rdchk("R1 reg2 ext", 2'd2, 8'h00);
    chk("R3 reset mode ext", {30'h0, bus_mode}, 32'd2);

    // R3 and R6 with external ROM strap
    for (int v = 0; v < 256; v++) begin
      wr(2'd0, 8'(v));
      rdchk("R6 reg0 ext", 2'd0, 8'(v) & 8'hC7);
      chk("R3 mode ext", {30'h0, bus_mode}, {30'h0, 1'b1, 1'(v >> 6)});
    end

    // R1 internal ROM strap, then R7/R8 gate sequence
    do_reset(1'b0);
    rdchk("R1 reg0 int", 2'd0, 8'h00);
    rdchk("R1 reg1 int", 2'd1, 8'h00);
    rdchk("R1 reg2 int", 2'd2, 8'h00);
    irq_in = '1; nmi_in = 1'b1;
    gate_chk("R7 after reset", 1'b0);
    pulse_insn(); pulse_insn();
    gate_chk("R7 no writes yet", 1'b0);
    wr(2'd0, 8'h00);
    gate_chk("R7 only reg0 written", 1'b0);
    wr(2'd1, 8'h00);
    gate_chk("R8 right after page write", 1'b0);
    pulse_insn();
    gate_chk("R8 after one boundary", 1'b0);
    pulse_insn();
    gate_chk("R7 open after second boundary", 1'b1);
    wr(2'd1, 8'h55);
    gate_chk("R8 rejected write still masks", 1'b0);
    pulse_insn();
    gate_chk("R8 one boundary again", 1'b0);
    pulse_insn();
    gate_chk("R8 reopened", 1'b1);
    irq_in = 8'hA5; nmi_in = 1'b0; #1;
    chk("R7 follow inputs", {23'h0, nmi_out, irq_out}, 32'h0A5);

    // R2 and R6 with internal ROM strap
    for (int v = 0; v < 256; v++) begin
      wr(2'd0, 8'(v));
      rdchk("R6 reg0 int", 2'd0, 8'(v) & 8'hC7);
      chk("R2 mode int", {30'h0, bus_mode}, {30'h0, 2'(v >> 6)});
    end
    rdchk("R6 unused select", 2'd3, 8'h00);

    // R5 stack page sweep in single-chip then expansion mode
    for (int m = 0; m < 2; m++) begin
      wr(2'd0, m == 1 ? 8'h80 : 8'h00);
      wr(2'd1, 8'h00);
      model = 8'h00;
      for (int v = 0; v < 256; v++) begin
        acc = (v == 0) || (m == 1 && v <= 8'h27);
        wr(2'd1, 8'(v));
        if (acc) model = 8'(v);
        rdchk("R5 page readback", 2'd1, model);
        chk("R5 page output", {24'h0, stack_page}, {24'h0, model});
      end
    end

    // R4 chip-enable pin mux, all enables and pin patterns
    for (int e = 0; e < 8; e++) begin
      wr(2'd0, 8'(e));
      for (int r = 0; r < 8; r++)
        for (int p = 0; p < 8; p++) begin
          ce_raw = 3'(r); port_ce = 3'(p); #1;
          chk("R4 ce pin", {29'h0, ce_pin},
              {29'h0, (3'(e) & 3'(r)) | (~3'(e) & 3'(p))});
        end
    end

    // R10 bus request pin mux
    for (int en = 0; en < 2; en++) begin
      wr(2'd2, en == 1 ? 8'h80 : 8'h00);
      for (int x = 0; x < 8; x++) begin
        breq_pin = x[0]; back_core = x[1]; port_back = x[2]; #1;
        chk("R10 breq/back",
            {29'h0, breq_core, breq_gpi, back_pin},
            en == 1 ? {29'h0, x[0], 1'b0, x[1]} : {29'h0, 1'b0, x[0], x[2]});
      end
    end

    // R9 stall length for each code, plus pulse during a stall
    for (int c = 0; c < 8; c++) begin
      wr(2'd2, 8'(c << 4));
      rdchk("R6 reg2 readback", 2'd2, 8'(c << 4));
      stall_len(-1, n);
      chk("R9 stall length", n, c);
    end
    wr(2'd2, 8'h70);
    stall_len(2, n);
    chk("R9 pulse during stall ignored", n, 7);
    wr(2'd2, 8'h00);
    ext_start = 1'b1; @(negedge clk); #1;
    chk("R9 zero code no stall", {31'h0, ext_ready}, 32'd1);
    ext_start = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule